// File: doc/BRIEF.md
# Adapter Input Window Protection Sequencer

This block sequences the enable of the main pass switch that connects an external adapter input to a system rail. Analog comparators upstream supply four digitized flags:
- input above the overvoltage threshold;
- input below the adjustable undervoltage threshold;
- input below the fixed internal undervoltage threshold;
- input present above a low plug-detect level.

A host supplies one bit that selects battery operation. A periodic timebase tick paces two timers: a debounce that must elapse before the pass switch first closes, and a blanking window that tolerates short undervoltage dips once the switch is closed.

Overvoltage opens the pass switch at once and never latches; the switch recloses after a fresh debounce. A sustained undervoltage, or any dip below the internal threshold while the switch is closed, latches the switch open. Only an unplug followed by a replug, seen on the plug-detect flag, re-arms it. While the input is in range, the host bit opens the main switch. The battery-switch enable follows the host bit in every state. Both timer lengths are parameters in ticks.

Top module: `inwin_guard`

## Requirements
- R1: While `overFlag` is 1, `mainEn` is 0 in that same cycle whatever `hostSel` is, with no blanking delay.
- R2: From the debounce state, `mainEn` rises in the cycle after the DEB_TICKS-th `tick` seen with the input inside the window (`overFlag`, `underAdjFlag` and `underIntFlag` all 0). It stays 0 during debounce whatever `hostSel` is.
- R3: Any cycle in debounce with the input outside the window restarts the count from zero. The switch stays off and no latch is set.
- R4: When overvoltage clears back into the window, `mainEn` returns only after a full new debounce of DEB_TICKS ticks, with no re-arm needed.
- R5: `underAdjFlag` rising while the switch is on starts a blanking interval and keeps `mainEn` on. Returning to the window before it expires resumes normal on operation.
- R6: During blanking, `hostSel`=1 forces `mainEn` to 0 and `hostSel`=0 lets it be 1.
- R7: If `underAdjFlag` is still 1 at the BLK_TICKS-th tick of blanking, the switch latches off. `mainEn` then stays 0 regardless of `hostSel` and the window flags until re-arm.
- R8: `underIntFlag`=1 while the switch is on or blanking drives `mainEn` to 0 in the same cycle and latches the switch off with no blanking.
- R9: A rising edge of `presentFlag` (a cycle with 1 after a cycle with 0) clears the latch and starts a new debounce from zero.
- R10: Once debounce has elapsed with the input in the window, `hostSel`=1 gives `mainEn`=0 and `hostSel`=0 gives `mainEn`=1. `mainEn` and `battEn` are never both 1.
- R11: `battEn` equals `hostSel` in every state, including reset and latched off.
- R12: Reset leaves the controller latched off with its counter cleared. A `presentFlag` held at 1 through reset release does not re-arm it; a low-then-high is required.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle timebase pulse advancing both timers |
| overFlag | input | 1 | Input above overvoltage threshold |
| underAdjFlag | input | 1 | Input below adjustable undervoltage threshold |
| underIntFlag | input | 1 | Input below internal undervoltage threshold |
| presentFlag | input | 1 | Input above plug-detect level |
| hostSel | input | 1 | Host request for battery operation |
| mainEn | output | 1 | Main pass switch enable, active high |
| battEn | output | 1 | Battery switchover enable, active high |

## Verification
The embedded assertions watch, on every cycle, these properties:
- the main enable is off under overvoltage and under internal undervoltage;
- the main enable is off in the latched state;
- the battery enable mirrors the host bit, and the two enables never overlap;
- the shared counter stays in range;
- every entry into the on state follows a completed debounce.

Exact tick counts for debounce and blanking, and the restart of debounce on a window exit, can only be shown by the bench's timed scenarios. The same holds for recovery from a brief dip, latch persistence against host and window changes, and re-arm only by an unplug/replug after reset.

// File: rtl/inwin_pkg.sv
package inwin_pkg;

  typedef enum logic [1:0] {
    ST_LOCK  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_ON    = 2'd2,
    ST_BLANK = 2'd3
  } guardState_t;

  // strobes from control to the timer datapath
  typedef struct packed {
    logic clr;
    logic inc;
  } ctrStb_t;

  // status from the timer datapath back to control
  typedef struct packed {
    logic debDone;
    logic blkDone;
  } ctrStat_t;

endpackage

// File: rtl/inwin_timer.sv
module inwin_timer
  import inwin_pkg::*;
#(
  parameter int DEB_TICKS = 25,
  parameter int BLK_TICKS = 25
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     tick,
  input  ctrStb_t  stb,
  output ctrStat_t stat
);

  localparam int MAXT = (DEB_TICKS > BLK_TICKS) ? DEB_TICKS : BLK_TICKS;
  localparam int CW   = $clog2(MAXT + 1);
  localparam logic [CW-1:0] DEB_LAST = CW'(DEB_TICKS - 1);
  localparam logic [CW-1:0] BLK_LAST = CW'(BLK_TICKS - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      cnt <= '0;
    else if (stb.clr)
      cnt <= '0;
    else if (stb.inc && tick)
      cnt <= cnt + 1'b1;
  end

  // the last tick of an interval is the one seen while the count sits at limit-1
  always_comb begin
    stat.debDone = tick && (cnt == DEB_LAST);
    stat.blkDone = tick && (cnt == BLK_LAST);
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    cnt < CW'(MAXT)); // R2

endmodule

// File: rtl/inwin_ctrl.sv
module inwin_ctrl
  import inwin_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     overFlag,
  input  logic     underAdjFlag,
  input  logic     underIntFlag,
  input  logic     presentFlag,
  input  logic     hostSel,
  input  ctrStat_t stat,
  output ctrStb_t  stb,
  output logic     mainEn
);

  guardState_t state, stateNxt;
  logic prevPres;
  logic presRise;
  logic inWin;

  // prevPres resets high so a flag held high through reset is not taken as a plug-in
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_LOCK;
      prevPres <= 1'b1;
    end else begin
      state    <= stateNxt;
      prevPres <= presentFlag;
    end
  end

  assign presRise = presentFlag && !prevPres;
  assign inWin    = !overFlag && !underAdjFlag && !underIntFlag;

  always_comb begin
    stateNxt = state;
    stb      = '{clr: 1'b1, inc: 1'b0};
    unique case (state)
      ST_LOCK: begin
        if (presRise) stateNxt = ST_WAIT;
      end
      ST_WAIT: begin
        if (!presRise && inWin) begin
          stb.clr = 1'b0;
          stb.inc = 1'b1;
          if (stat.debDone) begin
            stateNxt = ST_ON;
            stb.clr  = 1'b1;
          end
        end
      end
      ST_ON: begin
        if (presRise || overFlag) stateNxt = ST_WAIT;
        else if (underIntFlag)    stateNxt = ST_LOCK;
        else if (underAdjFlag)    stateNxt = ST_BLANK;
      end
      ST_BLANK: begin
        if (presRise || overFlag) stateNxt = ST_WAIT;
        else if (underIntFlag)    stateNxt = ST_LOCK;
        else if (!underAdjFlag)   stateNxt = ST_ON;
        else begin
          stb.clr = 1'b0;
          stb.inc = 1'b1;
          if (stat.blkDone) begin
            stateNxt = ST_LOCK;
            stb.clr  = 1'b1;
          end
        end
      end
      default: stateNxt = ST_LOCK;
    endcase
  end

  // fast-off paths are combinational so the switch opens in the fault cycle
  assign mainEn = ((state == ST_ON) || (state == ST_BLANK)) &&
                  !hostSel && !overFlag && !underIntFlag;

  AST_LATCH_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOCK) |-> !mainEn); // R7

  AST_ON_AFTER_DEB: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ON && $past(state) == ST_WAIT) |-> $past(stat.debDone)); // R2

  AST_INT_UV_OFF: assert property (@(posedge clk) disable iff (!rstN)
    underIntFlag |-> !mainEn); // R8

endmodule

// File: rtl/inwin_guard.sv
module inwin_guard
  import inwin_pkg::*;
#(
  parameter int DEB_TICKS = 25,
  parameter int BLK_TICKS = 25
) (
  input  logic clk,
  input  logic rstN,
  input  logic tick,
  input  logic overFlag,
  input  logic underAdjFlag,
  input  logic underIntFlag,
  input  logic presentFlag,
  input  logic hostSel,
  output logic mainEn,
  output logic battEn
);

  ctrStb_t  stb;
  ctrStat_t stat;

  inwin_timer #(.DEB_TICKS(DEB_TICKS), .BLK_TICKS(BLK_TICKS)) uTimer (
    .clk  (clk),
    .rstN (rstN),
    .tick (tick),
    .stb  (stb),
    .stat (stat)
  );

  inwin_ctrl uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .overFlag     (overFlag),
    .underAdjFlag (underAdjFlag),
    .underIntFlag (underIntFlag),
    .presentFlag  (presentFlag),
    .hostSel      (hostSel),
    .stat         (stat),
    .stb          (stb),
    .mainEn       (mainEn)
  );

  assign battEn = hostSel;

  AST_OV_OFF: assert property (@(posedge clk) disable iff (!rstN)
    overFlag |-> !mainEn); // R1

  AST_BATT_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
    battEn == hostSel); // R11

  AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(mainEn && battEn)); // R10

endmodule

// File: tb/sim_inwin_guard.sv
module sim_inwin_guard;

  localparam int DEB = 4;
  localparam int BLK = 3;
  localparam int NV  = 36;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b0, ov = 1'b0, ua = 1'b0, ui = 1'b0, pr = 1'b1, ho = 1'b0;
  logic mainEn, battEn;
  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk; // 125 MHz

  inwin_guard #(.DEB_TICKS(DEB), .BLK_TICKS(BLK)) u0 (
    .clk(clk), .rstN(rstN), .tick(tick), .overFlag(ov), .underAdjFlag(ua),
    .underIntFlag(ui), .presentFlag(pr), .hostSel(ho),
    .mainEn(mainEn), .battEn(battEn)
  );

  // {req[3:0], ov ua ui pr ho tk, expected mainEn}; each row: drive, one edge, then check
  localparam logic [10:0] VEC [NV] = '{
    {4'd12, 6'b000101, 1'b0}, // R12 held-high present does not arm
    {4'd9,  6'b000000, 1'b0}, // R9 unplug
    {4'd9,  6'b000101, 1'b0}, // R9 replug arms debounce
    {4'd2,  6'b000111, 1'b0}, // R2 tick 1, host ignored
    {4'd2,  6'b000101, 1'b0}, // R2 tick 2
    {4'd2,  6'b000101, 1'b0}, // R2 tick 3
    {4'd2,  6'b000101, 1'b1}, // R2 tick 4 -> on
    {4'd10, 6'b000110, 1'b0}, // R10 host high
    {4'd10, 6'b000100, 1'b1}, // R10 host low
    {4'd1,  6'b100100, 1'b0}, // R1 overvoltage
    {4'd1,  6'b100101, 1'b0}, // R1
    {4'd4,  6'b000101, 1'b0}, // R4 fresh debounce 1
    {4'd4,  6'b000101, 1'b0}, // R4 2
    {4'd3,  6'b010101, 1'b0}, // R3 exit restarts
    {4'd3,  6'b000101, 1'b0}, // R3 1
    {4'd3,  6'b000101, 1'b0}, // R3 2
    {4'd3,  6'b000101, 1'b0}, // R3 3
    {4'd3,  6'b000101, 1'b1}, // R3 4 -> on
    {4'd5,  6'b010101, 1'b1}, // R5 dip, blanking entered
    {4'd5,  6'b010101, 1'b1}, // R5 blank tick 1
    {4'd6,  6'b010111, 1'b0}, // R6 host off in blanking
    {4'd5,  6'b000100, 1'b1}, // R5 recovered
    {4'd7,  6'b010100, 1'b1}, // R7 second dip
    {4'd7,  6'b010101, 1'b1}, // R7 blank 1
    {4'd7,  6'b010101, 1'b1}, // R7 blank 2
    {4'd7,  6'b010101, 1'b0}, // R7 blank 3 -> latched
    {4'd7,  6'b000101, 1'b0}, // R7 window ok, still latched
    {4'd7,  6'b000111, 1'b0}, // R7 host toggles, still latched
    {4'd9,  6'b000000, 1'b0}, // R9 unplug
    {4'd9,  6'b000100, 1'b0}, // R9 replug without tick
    {4'd9,  6'b000101, 1'b0}, // R9 1
    {4'd9,  6'b000101, 1'b0}, // R9 2
    {4'd9,  6'b000101, 1'b0}, // R9 3
    {4'd9,  6'b000101, 1'b1}, // R9 4 -> on
    {4'd8,  6'b001100, 1'b0}, // R8 internal undervoltage
    {4'd8,  6'b000101, 1'b0}  // R8 latched
  };

  task automatic check(input int req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic step(input logic [5:0] f);
    @(negedge clk);
    {ov, ua, ui, pr, ho, tick} = f;
    @(posedge clk);
    #1;
  endtask

  task automatic rearmOn();
    step(6'b000000);
    step(6'b000100);
    for (int k = 0; k < DEB; k++) step(6'b000101);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    checks++;
    $display("FAIL watchdog expired (all requirements)");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(12, mainEn, 1'b0, "mainEn in reset");
    check(11, battEn, 1'b0, "battEn in reset");
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][6:1]);
      check(int'(VEC[i][10:7]), mainEn, VEC[i][0], $sformatf("row %0d mainEn", i));
      check(11, battEn, VEC[i][2], $sformatf("row %0d battEn (R11)", i)); // R11
    end

    // R1 and R8: same-cycle off before any clock edge
    rearmOn();
    check(2, mainEn, 1'b1, "rearm on");
    @(negedge clk);
    ov = 1'b1;
    #1;
    check(1, mainEn, 1'b0, "same-cycle overvoltage off");
    step(6'b000101);
    for (int k = 0; k < DEB - 1; k++) step(6'b000101);
    check(4, mainEn, 1'b1, "back on after overvoltage");
    @(negedge clk);
    ui = 1'b1;
    #1;
    check(8, mainEn, 1'b0, "same-cycle internal undervoltage off");
    @(posedge clk);
    #1;
    step(6'b000101);
    step(6'b000101);
    check(8, mainEn, 1'b0, "internal undervoltage latched");

    // R12: reset while on returns to latched, needs replug
    rearmOn();
    check(9, mainEn, 1'b1, "rearm before reset");
    @(negedge clk);
    rstN = 1'b0;
    @(posedge clk);
    #1;
    check(12, mainEn, 1'b0, "reset forces off");
    @(negedge clk);
    rstN = 1'b1;
    for (int k = 0; k < DEB + 2; k++) step(6'b000101);
    check(12, mainEn, 1'b0, "stays latched after reset");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule